// File: doc/BRIEF.md
# Word Address Pointer with Page and Array Rollover

This block keeps the 17-bit word address pointer of a two-wire serial memory. The protocol front end loads the pointer one field at a time as address bytes come in. The top bit comes from the device address byte. The next eight bits come from the first word-address byte, and the lowest eight bits come from the second. The front end then pulses an increment strobe after each data byte it moves. The pointer value drives the memory array and the page buffer.

One mode input decides how the pointer wraps. In write mode only the byte offset within the 256-byte page advances. The page number is held, so a burst that runs past the end of a page returns to the start of that same page. In read mode the whole 17-bit value advances, and it wraps from the last byte of the last of the 512 pages back to address zero.

The pointer keeps its value between transactions. After each access it holds the address that follows the last byte accessed, and a current-address read uses that value. Loading the word address during the dummy write of a random read also updates the pointer, even though no data byte follows.

Top module: `word_ptr`

## Requirements
- R1: While `rst_n` is low, and after its release until the first strobe, `addr` is 0.
- R2: A cycle with `ld_sel` high writes `sel_in` into `addr[16]` on the next edge. `addr[15:0]` is unchanged unless another load strobe is also high.
- R3: A cycle with `ld_hi` high writes `byte_in` into `addr[15:8]`. The other bits are unchanged unless another load strobe is also high.
- R4: A cycle with `ld_lo` high writes `byte_in` into `addr[7:0]`. The other bits are unchanged unless another load strobe is also high. This holds with no increment afterwards, as in a dummy write.
- R5: A cycle with `step` high, `rd_mode` low (write mode) and no load adds 1 modulo 256 to `addr[7:0]` and leaves `addr[16:8]` unchanged. For example, 0x123FF becomes 0x12300.
- R6: A cycle with `step` high, `rd_mode` high (read mode) and no load adds 1 modulo 2^17 to the whole of `addr`. For example, 0x012FF becomes 0x01300, and 0x1FFFF becomes 0x00000.
- R7: When any load strobe is high together with `step`, the loaded fields take the new values and no increment happens. Fields that are not loaded keep their values.
- R8: A cycle with no strobe leaves `addr` unchanged, whatever `rd_mode` and the data inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_sel | input | 1 | Load the top address bit from `sel_in` |
| ld_hi | input | 1 | Load address bits 15:8 from `byte_in` |
| ld_lo | input | 1 | Load address bits 7:0 from `byte_in` |
| step | input | 1 | Advance the pointer by one |
| rd_mode | input | 1 | 1 = read wrap (whole array), 0 = write wrap (within the page) |
| sel_in | input | 1 | Top address bit from the device address byte |
| byte_in | input | 8 | Word-address byte |
| addr | output | 17 | Current word address |

## Verification
The two wrap modes are tested from the same starting points, the last byte of a page and the last byte of the array. This shows whether a carry leaves the offset field: write mode must stay in the page and read mode must cross into the next page. Mid-page increments in both modes show that ordinary counting is the same in the two modes. Each field is loaded alone with a distinctive pattern, to confirm that each strobe reaches only its own bits. Loads combined with `step` confirm that the load takes priority. Idle cycles with `rd_mode` and `byte_in` toggling confirm that the pointer holds its value.

// File: rtl/word_ptr.sv
module word_ptr #(
  parameter int SEL_W  = 1,
  parameter int BYTE_W = 8,
  parameter int OFS_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ld_sel,
  input  logic                          ld_hi,
  input  logic                          ld_lo,
  input  logic                          step,
  input  logic                          rd_mode,
  input  logic [SEL_W-1:0]              sel_in,
  input  logic [BYTE_W-1:0]             byte_in,
  output logic [SEL_W+2*BYTE_W-1:0]     addr
);
  localparam int ADDR_W = SEL_W + 2*BYTE_W;
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              any_ld;
  logic [ADDR_W-1:0] nxt_rd, nxt_wr, nxt;

  assign any_ld = ld_sel | ld_hi | ld_lo;
  assign nxt_rd = ADDR_W'(addr + 1'b1);
  assign nxt_wr = {addr[ADDR_W-1:OFS_W], OFS_W'(addr[OFS_W-1:0] + 1'b1)};
  assign nxt    = rd_mode ? nxt_rd : nxt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (any_ld) begin
      if (ld_sel) addr[ADDR_W-1 -: SEL_W]    <= sel_in;
      if (ld_hi)  addr[2*BYTE_W-1 -: BYTE_W] <= byte_in;
      if (ld_lo)  addr[BYTE_W-1:0]           <= byte_in;
    end else if (step) begin
      addr <= nxt;
    end
  end

  a_r1_reset_zero: assert property (@(posedge clk) !rst_n |=> addr == '0);

  a_r2_sel_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_sel |=> addr[ADDR_W-1 -: SEL_W] == $past(sel_in));

  a_r4_lo_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld_lo |=> addr[BYTE_W-1:0] == $past(byte_in));

  a_r5_write_page_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !rd_mode && !ld_sel && !ld_hi && !ld_lo)
      |=> addr[ADDR_W-1 -: PAGE_W] == $past(addr[ADDR_W-1 -: PAGE_W]));

  a_r6_read_full_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (step && rd_mode && !any_ld && (&addr)) |=> addr == '0);

  a_r7_load_no_step: assert property (@(posedge clk) disable iff (!rst_n)
    (step && ld_hi && !ld_sel && !ld_lo)
      |=> addr[BYTE_W-1:0] == $past(addr[BYTE_W-1:0]));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !ld_sel && !ld_hi && !ld_lo) |=> $stable(addr));
endmodule

// File: tb/word_ptr_test.sv
module word_ptr_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_sel = 1'b0, ld_hi = 1'b0, ld_lo = 1'b0, step = 1'b0, rd_mode = 1'b0;
  logic [0:0]  sel_in = '0;
  logic [7:0]  byte_in = '0;
  logic [16:0] addr;
  int          n_chk = 0, n_bad = 0;
  bit          done = 0;

  always #5 clk = ~clk;

  word_ptr uut (.clk(clk), .rst_n(rst_n), .ld_sel(ld_sel), .ld_hi(ld_hi), .ld_lo(ld_lo),
                .step(step), .rd_mode(rd_mode), .sel_in(sel_in), .byte_in(byte_in), .addr(addr));

  task automatic chk(input string req, input logic [16:0] exp);
    n_chk++;
    if (addr !== exp) begin
      n_bad++;
      $display("FAIL %s: addr=%05h expected=%05h", req, addr, exp);
    end
  endtask

  task automatic cyc(input logic s, input logic h, input logic l, input logic st,
                     input logic rd, input logic sv, input logic [7:0] bv);
    ld_sel = s; ld_hi = h; ld_lo = l; step = st; rd_mode = rd; sel_in = sv; byte_in = bv;
    @(posedge clk); @(negedge clk);
    ld_sel = 0; ld_hi = 0; ld_lo = 0; step = 0;
  endtask

  task automatic set_addr(input logic [16:0] a);
    cyc(1, 1, 0, 0, 0, a[16], a[15:8]);
    cyc(0, 0, 1, 0, 0, 0, a[7:0]);
  endtask

  task automatic t_reset;
    @(negedge clk); chk("R1", 17'h0);
    rst_n = 1; @(negedge clk); @(negedge clk); chk("R1", 17'h0);
  endtask

  task automatic t_loads;
    cyc(1, 0, 0, 0, 0, 1, 8'h00); chk("R2", 17'h10000);
    cyc(0, 1, 0, 0, 0, 0, 8'hA5); chk("R3", 17'h1A500);
    cyc(0, 0, 1, 0, 0, 0, 8'h3C); chk("R4", 17'h1A53C);
    cyc(1, 0, 0, 0, 1, 0, 8'hFF); chk("R2", 17'h0A53C);
    repeat (3) @(negedge clk); chk("R4", 17'h0A53C);
  endtask

  task automatic t_write_wrap;
    set_addr(17'h123FE);
    cyc(0, 0, 0, 1, 0, 0, 0); chk("R5", 17'h123FF);
    cyc(0, 0, 0, 1, 0, 0, 0); chk("R5", 17'h12300);
    set_addr(17'h1FFFF);
    cyc(0, 0, 0, 1, 0, 0, 0); chk("R5", 17'h1FF00);
  endtask

  task automatic t_read_wrap;
    set_addr(17'h012FF);
    cyc(0, 0, 0, 1, 1, 0, 0); chk("R6", 17'h01300);
    set_addr(17'h0FFFF);
    cyc(0, 0, 0, 1, 1, 0, 0); chk("R6", 17'h10000);
    set_addr(17'h1FFFF);
    cyc(0, 0, 0, 1, 1, 0, 0); chk("R6", 17'h00000);
    cyc(0, 0, 0, 1, 1, 0, 0); chk("R6", 17'h00001);
  endtask

  task automatic t_priority;
    set_addr(17'h04510);
    cyc(0, 1, 0, 1, 1, 0, 8'h77); chk("R7", 17'h07710);
    cyc(0, 0, 1, 1, 0, 0, 8'hFF); chk("R7", 17'h077FF);
    cyc(1, 0, 0, 1, 1, 1, 8'h00); chk("R7", 17'h177FF);
  endtask

  task automatic t_hold;
    set_addr(17'h15555);
    for (int i = 0; i < 4; i++) begin
      rd_mode = i[0]; byte_in = 8'(i * 37); sel_in = ~sel_in;
      @(negedge clk);
    end
    chk("R8", 17'h15555);
  endtask

  initial begin
    t_reset;
    t_loads;
    t_write_wrap;
    t_read_wrap;
    t_priority;
    t_hold;
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1ms;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule